// File: doc/BRIEF.md
# In-Order Trap Commit Unit

This block sits beside a five-stage pipeline (fetch, decode, execute, memory, writeback) and decides when a fault becomes a trap. Any of the first four stages may report a fault for the instruction it currently holds. The report is a one-cycle request with a 4-bit cause. The block attaches the fault to that instruction and carries it down its own copy of the stage registers. An instruction keeps only the first fault it collects.

Nothing is acted on until the instruction leaves the memory stage. At that one commit point the oldest instruction in flight is the only one that can trap, so faults are always taken in program order. A younger instruction may have faulted earlier in time, for example a fetch fault raised while an older load is still on its way to a data-side fault. On acceptance the block does four things. It suppresses the faulting instruction's writes. It kills every younger instruction together with any fault it recorded. It saves the faulting PC and cause. On the next cycle it steers fetch to a fixed handler address. A return request kills everything in flight and, on the next cycle, steers fetch back to the saved PC so that the discarded instructions run again.

Control is a three-state machine. RUN is normal flow. VECTOR is the one-cycle redirect to the handler. RESUME is the one-cycle redirect to the saved PC. The transitions are: RUN to VECTOR on trap acceptance; RUN to RESUME on a return request with no trap in the same cycle; VECTOR to RUN and RESUME to RUN unconditionally.

Top module: `exc_order_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, commit_valid, kill, trap_taken and redirect_valid are 0, and epc and ecause read 0.
- R2: A fault-free instruction presented with fetch_valid in cycle c shows commit_valid=1 with commit_pc equal to its PC in cycle c+3, unless it was killed.
- R3: Stage k is fetch for k=0, decode for 1, execute for 2 and memory for 3. It reports a fault with fault_req[k], and its cause sits on fault_cause[4k+3:4k]. The fault marks the instruction in stage k at that moment. The trap is taken only when that instruction reaches the memory stage: trap_taken=1 and kill=1 in cycle c+3 for an instruction fetched in cycle c, with commit_valid=0 in that cycle.
- R4: When an older instruction faults, its trap is taken even if a younger instruction raised its own fault earlier in time. The younger one's fault is never taken.
- R5: An instruction that faults in several stages traps with the cause of its earliest-stage fault.
- R6: In the cycle after trap_taken, redirect_valid=1, redirect_pc equals HANDLER_VEC, and epc and ecause hold the trapped instruction's PC and cause. epc and ecause change at no other time.
- R7: After a trap, no younger instruction commits or traps. This covers instructions presented at fetch in the trap cycle and in the following cycle. kill is followed by a cycle with commit_valid=0.
- R8: A fault request in a stage that holds no instruction has no effect: no trap, no kill, and epc and ecause unchanged.
- R9: A return request (ret_req) in RUN with no trap that cycle raises kill, kills every in-flight instruction including the one in the memory stage, and gives redirect_valid=1 with redirect_pc equal to epc in the next cycle.
- R10: A trap and a return in the same cycle resolve as the trap: the next redirect goes to HANDLER_VEC. A return request during a redirect cycle is ignored.
- R11: redirect_valid lasts exactly one cycle (VECTOR or RESUME), after which the machine is back in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction enters the fetch stage this cycle |
| fetch_pc | input | PC_W | PC of the instruction entering fetch |
| fault_req | input | 4 | Per-stage fault request, bit k for stage k |
| fault_cause | input | 4*CAUSE_W | Per-stage cause, field k at [CAUSE_W*k +: CAUSE_W] |
| ret_req | input | 1 | Return from handler: restart at the saved PC |
| commit_valid | output | 1 | Memory-stage instruction retires with its writes enabled |
| commit_pc | output | PC_W | PC of the retiring instruction |
| kill | output | 1 | Discard all in-flight instructions this cycle |
| trap_taken | output | 1 | Memory-stage instruction's fault is accepted this cycle |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | PC_W | Handler vector or saved PC |
| epc | output | PC_W | Saved PC of the last trapped instruction |
| ecause | output | CAUSE_W | Saved cause of the last trapped instruction |

## Verification
The hardest case to reach from the ports is an out-of-order fault pair. An older instruction faults late, in execute or memory. A younger one faults earlier in time, in fetch or decode, while the older one is still in flight. Only the older fault may surface. The bench reaches this case with a sweep. It issues a stream of back-to-back instructions. It gives the first instruction every one of the sixteen sets of fault stages and the second instruction every single fault stage or none. Each request pulse is timed to the cycle in which its instruction occupies that stage. Pulses that fall on slots already killed or emptied check the discard and empty-slot rules along the way.

// File: rtl/exc_order_pkg.sv
package exc_order_pkg;

    // Fault-reporting stages: 0 fetch, 1 decode, 2 execute, 3 memory.
    localparam int FLT_STAGES = 4;
    localparam int STG_MEM    = FLT_STAGES - 1;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_VECTOR = 2'd1,
        ST_RESUME = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/exc_fault_merge.sv
// Folds a stage's fault request into the record of the instruction held there.
// The first fault an instruction collects wins.
module exc_fault_merge #(
    parameter int CAUSE_W = 4
) (
    input  logic               in_valid,
    input  logic               in_exc,
    input  logic [CAUSE_W-1:0] in_cause,
    input  logic               req,
    input  logic [CAUSE_W-1:0] req_cause,
    output logic               out_exc,
    output logic [CAUSE_W-1:0] out_cause
);

    logic new_hit;

    always_comb begin
        new_hit = in_valid & req & ~in_exc;
        out_exc = in_exc | new_hit;
        if (in_exc) begin
            out_cause = in_cause;
        end else if (new_hit) begin
            out_cause = req_cause;
        end else begin
            out_cause = '0;
        end
    end

endmodule

// File: rtl/exc_stage_slot.sv
// One stage boundary of the trap-tracking shadow pipeline.
module exc_stage_slot #(
    parameter int PC_W    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               d_valid,
    input  logic               d_exc,
    input  logic [CAUSE_W-1:0] d_cause,
    input  logic [PC_W-1:0]    d_pc,
    output logic               q_valid,
    output logic               q_exc,
    output logic [CAUSE_W-1:0] q_cause,
    output logic [PC_W-1:0]    q_pc
);

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            q_valid <= 1'b0;
            q_exc   <= 1'b0;
            q_cause <= '0;
            q_pc    <= '0;
        end else begin
            q_valid <= d_valid;
            q_exc   <= d_valid & d_exc;
            q_cause <= d_valid ? d_cause : '0;
            q_pc    <= d_pc;
        end
    end

endmodule

// File: rtl/exc_commit_ctl.sv
// Commit-point control: trap acceptance, return, redirect and saved state.
module exc_commit_ctl
    import exc_order_pkg::*;
#(
    parameter int              PC_W        = 32,
    parameter int              CAUSE_W     = 4,
    parameter logic [PC_W-1:0] HANDLER_VEC = 'h400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               m_valid,
    input  logic               m_exc,
    input  logic [CAUSE_W-1:0] m_cause,
    input  logic [PC_W-1:0]    m_pc,
    input  logic               ret_req,
    output logic               fetch_open,
    output logic               kill,
    output logic               trap_taken,
    output logic               commit_valid,
    output logic [PC_W-1:0]    commit_pc,
    output logic               redirect_valid,
    output logic [PC_W-1:0]    redirect_pc,
    output logic [PC_W-1:0]    epc,
    output logic [CAUSE_W-1:0] ecause
);

    ctl_state_e state_q;
    ctl_state_e state_d;
    logic       in_run;
    logic       take_trap;
    logic       take_ret;

    assign in_run    = (state_q == ST_RUN);
    assign take_trap = in_run & m_valid & m_exc;
    assign take_ret  = in_run & ret_req & ~take_trap;

    // State register together with the saved PC and cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            epc     <= '0;
            ecause  <= '0;
        end else begin
            state_q <= state_d;
            if (take_trap) begin
                epc    <= m_pc;
                ecause <= m_cause;
            end
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (take_trap) begin
                    state_d = ST_VECTOR;
                end else if (take_ret) begin
                    state_d = ST_RESUME;
                end
            end
            ST_VECTOR: state_d = ST_RUN;
            ST_RESUME: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // Outputs.
    always_comb begin
        fetch_open     = 1'b0;
        kill           = 1'b0;
        trap_taken     = 1'b0;
        commit_valid   = 1'b0;
        commit_pc      = m_pc;
        redirect_valid = 1'b0;
        redirect_pc    = HANDLER_VEC;
        unique case (state_q)
            ST_RUN: begin
                fetch_open   = 1'b1;
                trap_taken   = take_trap;
                kill         = take_trap | take_ret;
                commit_valid = m_valid & ~m_exc & ~ret_req;
            end
            ST_VECTOR: begin
                redirect_valid = 1'b1;
                redirect_pc    = HANDLER_VEC;
            end
            ST_RESUME: begin
                redirect_valid = 1'b1;
                redirect_pc    = epc;
            end
            default: begin
                redirect_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/exc_order_unit.sv
module exc_order_unit
    import exc_order_pkg::*;
#(
    parameter int              PC_W        = 32,
    parameter int              CAUSE_W     = 4,
    parameter logic [PC_W-1:0] HANDLER_VEC = 'h400
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fetch_valid,
    input  logic [PC_W-1:0]               fetch_pc,
    input  logic [FLT_STAGES-1:0]         fault_req,
    input  logic [FLT_STAGES*CAUSE_W-1:0] fault_cause,
    input  logic                          ret_req,
    output logic                          commit_valid,
    output logic [PC_W-1:0]               commit_pc,
    output logic                          kill,
    output logic                          trap_taken,
    output logic                          redirect_valid,
    output logic [PC_W-1:0]               redirect_pc,
    output logic [PC_W-1:0]               epc,
    output logic [CAUSE_W-1:0]            ecause
);

    // Record held in each stage (index 0 is the fetch input itself).
    logic [FLT_STAGES-1:0]              st_valid;
    logic [FLT_STAGES-1:0]              st_exc;
    logic [FLT_STAGES-1:0][CAUSE_W-1:0] st_cause;
    logic [FLT_STAGES-1:0][PC_W-1:0]    st_pc;
    // Record after folding in that stage's own fault request.
    logic [FLT_STAGES-1:0]              mg_exc;
    logic [FLT_STAGES-1:0][CAUSE_W-1:0] mg_cause;

    logic               fetch_open;
    logic               mem_valid;
    logic               mem_exc;
    logic [CAUSE_W-1:0] mem_cause;
    logic [PC_W-1:0]    mem_pc;

    assign st_valid[0] = fetch_valid & fetch_open;
    assign st_exc[0]   = 1'b0;
    assign st_cause[0] = '0;
    assign st_pc[0]    = fetch_pc;

    for (genvar k = 0; k < FLT_STAGES; k++) begin : g_stage
        exc_fault_merge #(
            .CAUSE_W (CAUSE_W)
        ) u_merge (
            .in_valid  (st_valid[k]),
            .in_exc    (st_exc[k]),
            .in_cause  (st_cause[k]),
            .req       (fault_req[k]),
            .req_cause (fault_cause[k*CAUSE_W +: CAUSE_W]),
            .out_exc   (mg_exc[k]),
            .out_cause (mg_cause[k])
        );
        if (k < STG_MEM) begin : g_slot
            exc_stage_slot #(
                .PC_W    (PC_W),
                .CAUSE_W (CAUSE_W)
            ) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .flush   (kill),
                .d_valid (st_valid[k]),
                .d_exc   (mg_exc[k]),
                .d_cause (mg_cause[k]),
                .d_pc    (st_pc[k]),
                .q_valid (st_valid[k+1]),
                .q_exc   (st_exc[k+1]),
                .q_cause (st_cause[k+1]),
                .q_pc    (st_pc[k+1])
            );
        end
    end

    assign mem_valid = st_valid[STG_MEM];
    assign mem_exc   = mg_exc[STG_MEM];
    assign mem_cause = mg_cause[STG_MEM];
    assign mem_pc    = st_pc[STG_MEM];

    exc_commit_ctl #(
        .PC_W        (PC_W),
        .CAUSE_W     (CAUSE_W),
        .HANDLER_VEC (HANDLER_VEC)
    ) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .m_valid        (mem_valid),
        .m_exc          (mem_exc),
        .m_cause        (mem_cause),
        .m_pc           (mem_pc),
        .ret_req        (ret_req),
        .fetch_open     (fetch_open),
        .kill           (kill),
        .trap_taken     (trap_taken),
        .commit_valid   (commit_valid),
        .commit_pc      (commit_pc),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .epc            (epc),
        .ecause         (ecause)
    );

endmodule

// File: rtl/exc_order_chk.sv
module exc_order_chk #(
    parameter int              PC_W        = 32,
    parameter int              CAUSE_W     = 4,
    parameter logic [PC_W-1:0] HANDLER_VEC = 'h400
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ret_req,
    input logic               kill,
    input logic               trap_taken,
    input logic               commit_valid,
    input logic               redirect_valid,
    input logic [PC_W-1:0]    redirect_pc,
    input logic [PC_W-1:0]    epc,
    input logic [CAUSE_W-1:0] ecause,
    input logic [PC_W-1:0]    mem_pc,
    input logic [CAUSE_W-1:0] mem_cause
);

    p_single_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_taken, commit_valid}));

    p_vector_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> (redirect_valid && redirect_pc == HANDLER_VEC
                        && epc == $past(mem_pc) && ecause == $past(mem_cause)));

    p_saved_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_taken |=> ($stable(epc) && $stable(ecause)));

    p_drained_after_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !commit_valid);

    p_resume_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_taken && !redirect_valid)
            |=> (redirect_valid && redirect_pc == $past(epc)));

    p_trap_over_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && ret_req) |=> (redirect_valid && redirect_pc == HANDLER_VEC));

    p_redirect_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    p_redirect_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> redirect_valid);

endmodule

bind exc_order_unit exc_order_chk #(
    .PC_W        (PC_W),
    .CAUSE_W     (CAUSE_W),
    .HANDLER_VEC (HANDLER_VEC)
) u_exc_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ret_req        (ret_req),
    .kill           (kill),
    .trap_taken     (trap_taken),
    .commit_valid   (commit_valid),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .epc            (epc),
    .ecause         (ecause),
    .mem_pc         (mem_pc),
    .mem_cause      (mem_cause)
);

// File: tb/exc_order_unit_tb_top.sv
`timescale 1ns/1ps
module exc_order_unit_tb_top;

    localparam int          PC_W = 32;
    localparam int          CW   = 4;
    localparam logic [31:0] VEC  = 32'h0000_0400;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_valid = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic [3:0]      fault_req = '0;
    logic [15:0]     fault_cause = '0;
    logic            ret_req = 1'b0;
    logic            commit_valid;
    logic [PC_W-1:0] commit_pc;
    logic            kill;
    logic            trap_taken;
    logic            redirect_valid;
    logic [PC_W-1:0] redirect_pc;
    logic [PC_W-1:0] epc;
    logic [CW-1:0]   ecause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exc_order_unit #(.PC_W(PC_W), .CAUSE_W(CW), .HANDLER_VEC(VEC)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fault_req(fault_req), .fault_cause(fault_cause), .ret_req(ret_req),
        .commit_valid(commit_valid), .commit_pc(commit_pc), .kill(kill),
        .trap_taken(trap_taken), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .epc(epc), .ecause(ecause)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fetch_valid = 1'b0;
        fault_req   = '0;
        fault_cause = '0;
        ret_req     = 1'b0;
    endtask

    // Instruction A issued in cycle 0 faults in every stage set in mask_a.
    // Instruction B issued in cycle 1 faults in stage sb (sb==4: no fault).
    task automatic run_case(input int idx_case, input logic [3:0] mask_a, input int sb);
        logic [31:0] base;
        logic [31:0] epc_before;
        logic [3:0]  exp_code;
        int          taker;
        int          ta;
        base       = 32'h0001_0000 + 32'(idx_case) * 32'h100;
        epc_before = epc;
        taker      = -1;
        exp_code   = '0;
        for (int s = 3; s >= 0; s--) begin
            if (mask_a[s]) begin
                taker    = 0;
                exp_code = 4'(s + 1);
            end
        end
        if (taker < 0 && sb < 4) begin
            taker    = 1;
            exp_code = 4'(sb + 9);
        end
        ta = (taker >= 0) ? taker + 3 : 100;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            idle_inputs();
            fetch_valid = (c < 6) && (c <= ta + 1);
            fetch_pc    = base + 32'(4 * c);
            for (int s = 0; s < 4; s++) begin
                if (mask_a[s] && c == s) begin
                    fault_req[s]         = 1'b1;
                    fault_cause[s*4 +: 4] = 4'(s + 1);
                end
                if (sb < 4 && s == sb && c == 1 + sb) begin
                    fault_req[s]         = 1'b1;
                    fault_cause[s*4 +: 4] = 4'(s + 9);
                end
            end
            // Fault on an empty memory slot once the stream has drained (R8).
            if (taker < 0 && c == 10) begin
                fault_req[3]        = 1'b1;
                fault_cause[12 +: 4] = 4'hF;
            end
            #1;
            begin
                int  j;
                bit  exp_commit;
                j = c - 3;
                exp_commit = (j >= 0) && (j < 6) && (c < ta);
                chk($sformatf("R2 commit_valid case%0d cyc%0d", idx_case, c), 32'(commit_valid), 32'(exp_commit));
                if (exp_commit)
                    chk($sformatf("R2 commit_pc case%0d cyc%0d", idx_case, c), commit_pc, base + 32'(4 * j));
                chk($sformatf("R3 R4 R7 R8 trap_taken case%0d cyc%0d", idx_case, c), 32'(trap_taken), 32'(c == ta));
                chk($sformatf("R3 R7 kill case%0d cyc%0d", idx_case, c), 32'(kill), 32'(c == ta));
                chk($sformatf("R11 redirect_valid case%0d cyc%0d", idx_case, c), 32'(redirect_valid), 32'(c == ta + 1));
                if (c == ta + 1) begin
                    chk($sformatf("R6 redirect_pc case%0d", idx_case), redirect_pc, VEC);
                    chk($sformatf("R4 epc case%0d", idx_case), epc, base + 32'(4 * taker));
                    chk($sformatf("R5 ecause case%0d", idx_case), 32'(ecause), 32'(exp_code));
                end
            end
        end
        if (taker < 0) begin
            chk($sformatf("R6 R8 epc hold case%0d", idx_case), epc, epc_before);
        end else begin
            // Return to the saved PC (R9).
            @(negedge clk);
            idle_inputs();
            ret_req = 1'b1;
            #1;
            chk($sformatf("R9 kill on return case%0d", idx_case), 32'(kill), 32'd1);
            @(negedge clk);
            idle_inputs();
            #1;
            chk($sformatf("R9 resume valid case%0d", idx_case), 32'(redirect_valid), 32'd1);
            chk($sformatf("R9 resume pc case%0d", idx_case), redirect_pc, base + 32'(4 * taker));
            @(negedge clk);
            #1;
            chk($sformatf("R11 resume one cycle case%0d", idx_case), 32'(redirect_valid), 32'd0);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 commit in reset", 32'(commit_valid), 32'd0);
        chk("R1 redirect in reset", 32'(redirect_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 commit after reset", 32'(commit_valid), 32'd0);
        chk("R1 kill after reset", 32'(kill), 32'd0);
        chk("R1 trap after reset", 32'(trap_taken), 32'd0);
        chk("R1 redirect after reset", 32'(redirect_valid), 32'd0);
        chk("R1 epc after reset", epc, 32'd0);
        chk("R1 ecause after reset", 32'(ecause), 32'd0);

        // Sweep of fault placements over two back-to-back instructions.
        for (int ma = 0; ma < 16; ma++) begin
            for (int sb = 0; sb < 5; sb++) begin
                run_case(ma * 5 + sb, 4'(ma), sb);
            end
        end

        // R10: trap and return in the same cycle; return during redirect ignored.
        @(negedge clk);
        idle_inputs();
        fetch_valid = 1'b1;
        fetch_pc    = 32'h0002_0000;
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            idle_inputs();
            if (c == 3) begin
                fault_req[3]        = 1'b1;
                fault_cause[12 +: 4] = 4'h7;
                ret_req             = 1'b1;
            end
        end
        #1;
        chk("R10 trap wins over return", 32'(trap_taken), 32'd1);
        @(negedge clk);
        idle_inputs();
        ret_req = 1'b1;
        #1;
        chk("R10 redirect to vector", redirect_pc, VEC);
        chk("R10 no kill during redirect", 32'(kill), 32'd0);
        @(negedge clk);
        idle_inputs();
        #1;
        chk("R10 return during redirect ignored", 32'(redirect_valid), 32'd0);
        chk("R10 epc from trap", epc, 32'h0002_0000);

        // R9: return kills in-flight instructions, memory stage included.
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            idle_inputs();
            fetch_valid = 1'b1;
            fetch_pc    = 32'h0003_0000 + 32'(4 * c);
        end
        @(negedge clk);
        idle_inputs();
        ret_req = 1'b1;
        #1;
        chk("R9 memory-stage instruction killed", 32'(commit_valid), 32'd0);
        chk("R9 kill on return", 32'(kill), 32'd1);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            idle_inputs();
            #1;
            chk($sformatf("R9 no commit after return cyc%0d", c), 32'(commit_valid), 32'd0);
            if (c == 0) chk("R9 resume to epc", redirect_pc, 32'h0002_0000);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule